// File: doc/BRIEF.md
# Spike Event Flit Packetizer

This block produces synthetic spike events and puts each one on a router port as a fixed-length train of 64-bit flits. A free-running pseudo-random generator moves forward once per time step. On each step its value is compared with a firing-rate input, and the result decides whether an event is produced. An event captures the destination node address and a 512-bit payload. The message leaves as one header flit and then nine numbered tail flits.

The output is a valid/ready stream. Each flit carries its sequence position in its four low bits, so a receiver can check ordering and reassemble the payload without any side information. Only one message is serialized at a time. An event that fires while a message is still leaving is discarded, and a saturating counter records the loss.

Top module: `spike_pkt_packetizer`

## Requirements
- R1: Every message is exactly ten 64-bit flits. Bits [3:0] hold the sequence code: 0 for the header, which always comes first, then 1 through 9 for the tails in increasing order, with no gaps.
- R2: Header bits [63:57] equal the destination address that was present on the cycle the event fired.
- R3: The payload is carried MSB first. Header bits [56:4] hold payload[511:459]. Each tail k holds the next 60 payload bits in its bits [63:4]. All bit positions after the last payload bit are zero.
- R4: A flit transfers on a clock edge where valid and ready are both high. While valid is high and ready is low, valid and the flit stay unchanged. After the tail with code 9 transfers, valid goes low.
- R5: An event fires on a step cycle when the rate input is all ones, or when the generator value is below the rate. A rate of zero never fires. Valid rises on the edge that follows the firing step.
- R6: An event that fires while valid is high is dropped. It leaves the message in progress unchanged and increments an overflow counter, which saturates at all ones and does not change while valid is low.
- R7: After reset, valid is low and the overflow counter reads zero.
- R8: An intermediate rate fires on some steps but not on all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepPulse | input | 1 | One-cycle time-step strobe |
| rateIn | input | RATE_W (16) | Firing-rate threshold |
| destAddr | input | DEST_W (7) | Destination node address for new events |
| eventPayload | input | PAYLOAD_W (512) | Event data captured when an event fires |
| flitData | output | FLIT_W (64) | Current flit |
| flitValid | output | 1 | Flit is valid |
| flitReady | input | 1 | Downstream accepts the flit |
| overflowCount | output | OVF_W (8) | Saturating count of dropped events |

## Verification
The hardest state to reach from the ports is the saturated overflow counter with the original message still intact. To get there, the bench holds ready low at full rate, starts one message, and then sends more than 255 further steps while the payload and destination inputs change. It then drains the stream and checks that the reassembled message matches the first event exactly. Random ready patterns test the hold behaviour. An intermediate rate is checked only by the outcome that some steps fire and some do not, so the bench does not depend on the generator's polynomial.

// File: rtl/spike_pkt_pkg.sv
package spike_pkt_pkg;
  localparam int SEQ_W = 4;

  typedef struct packed {
    logic             load;
    logic             advance;
    logic [SEQ_W-1:0] seq;
  } pktStrobe_t;
endpackage

// File: rtl/spike_pkt_ctrl.sv
module spike_pkt_ctrl
  import spike_pkt_pkg::*;
#(
  parameter int RATE_W    = 16,
  parameter int NUM_TAILS = 9,
  parameter int OVF_W     = 8,
  parameter logic [RATE_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [RATE_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepPulse,
  input  logic [RATE_W-1:0] rateIn,
  input  logic              flitReady,
  output logic              flitValid,
  output logic [OVF_W-1:0]  overflowCount,
  output pktStrobe_t        strobe
);
  localparam logic [SEQ_W-1:0] LAST_SEQ = SEQ_W'(NUM_TAILS);

  logic [RATE_W-1:0] lfsr;
  logic [SEQ_W-1:0]  seqCnt;
  logic              busy;
  logic              rateHit;
  logic              fire;
  logic              xfer;

  always_comb begin
    rateHit        = (rateIn == '1) || (lfsr < rateIn);
    fire           = stepPulse && rateHit;
    xfer           = busy && flitReady;
    strobe.load    = fire && !busy;
    strobe.advance = xfer;
    strobe.seq     = seqCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr <= LFSR_SEED;
    end else if (stepPulse) begin
      lfsr <= {1'b0, lfsr[RATE_W-1:1]} ^ (lfsr[0] ? LFSR_TAPS : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      seqCnt <= '0;
    end else if (strobe.load) begin
      busy   <= 1'b1;
      seqCnt <= '0;
    end else if (xfer) begin
      if (seqCnt == LAST_SEQ) begin
        busy   <= 1'b0;
        seqCnt <= '0;
      end else begin
        seqCnt <= seqCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overflowCount <= '0;
    end else if (fire && busy && (overflowCount != '1)) begin
      overflowCount <= overflowCount + 1'b1;
    end
  end

  assign flitValid = busy;
endmodule

// File: rtl/spike_pkt_datapath.sv
module spike_pkt_datapath
  import spike_pkt_pkg::*;
#(
  parameter int FLIT_W    = 64,
  parameter int DEST_W    = 7,
  parameter int PAYLOAD_W = 512,
  parameter int NUM_TAILS = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pktStrobe_t           strobe,
  input  logic [DEST_W-1:0]    destAddr,
  input  logic [PAYLOAD_W-1:0] eventPayload,
  output logic [FLIT_W-1:0]    flitData
);
  localparam int HDR_BITS  = FLIT_W - DEST_W - SEQ_W;
  localparam int TAIL_BITS = FLIT_W - SEQ_W;
  localparam int CAP_BITS  = HDR_BITS + NUM_TAILS * TAIL_BITS;
  localparam int PAD_BITS  = CAP_BITS - PAYLOAD_W;

  logic [CAP_BITS-1:0] bitQueue;
  logic [DEST_W-1:0]   destReg;
  logic                atHeader;

  assign atHeader = (strobe.seq == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitQueue <= '0;
      destReg  <= '0;
    end else if (strobe.load) begin
      bitQueue <= {eventPayload, {PAD_BITS{1'b0}}};
      destReg  <= destAddr;
    end else if (strobe.advance) begin
      if (atHeader) bitQueue <= bitQueue << HDR_BITS;
      else          bitQueue <= bitQueue << TAIL_BITS;
    end
  end

  always_comb begin
    if (atHeader)
      flitData = {destReg, bitQueue[CAP_BITS-1 -: HDR_BITS], {SEQ_W{1'b0}}};
    else
      flitData = {bitQueue[CAP_BITS-1 -: TAIL_BITS], strobe.seq};
  end
endmodule

// File: rtl/spike_pkt_packetizer.sv
module spike_pkt_packetizer
  import spike_pkt_pkg::*;
#(
  parameter int FLIT_W    = 64,
  parameter int DEST_W    = 7,
  parameter int PAYLOAD_W = 512,
  parameter int NUM_TAILS = 9,
  parameter int RATE_W    = 16,
  parameter int OVF_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stepPulse,
  input  logic [RATE_W-1:0]    rateIn,
  input  logic [DEST_W-1:0]    destAddr,
  input  logic [PAYLOAD_W-1:0] eventPayload,
  output logic [FLIT_W-1:0]    flitData,
  output logic                 flitValid,
  input  logic                 flitReady,
  output logic [OVF_W-1:0]     overflowCount
);
  pktStrobe_t strobe;

  spike_pkt_ctrl #(
    .RATE_W(RATE_W), .NUM_TAILS(NUM_TAILS), .OVF_W(OVF_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .stepPulse(stepPulse), .rateIn(rateIn),
    .flitReady(flitReady), .flitValid(flitValid),
    .overflowCount(overflowCount), .strobe(strobe)
  );

  spike_pkt_datapath #(
    .FLIT_W(FLIT_W), .DEST_W(DEST_W), .PAYLOAD_W(PAYLOAD_W), .NUM_TAILS(NUM_TAILS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .destAddr(destAddr),
    .eventPayload(eventPayload), .flitData(flitData)
  );
endmodule

// File: rtl/spike_pkt_checker.sv
module spike_pkt_checker #(
  parameter int FLIT_W    = 64,
  parameter int NUM_TAILS = 9,
  parameter int RATE_W    = 16,
  parameter int OVF_W     = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [FLIT_W-1:0] flitData,
  input logic              flitValid,
  input logic              flitReady,
  input logic [RATE_W-1:0] rateIn,
  input logic [OVF_W-1:0]  overflowCount
);
  localparam logic [3:0] LAST = 4'(NUM_TAILS);

  AST_SEQ_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    flitValid |-> flitData[3:0] <= LAST); // R1
  AST_HEADER_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flitValid) |-> flitData[3:0] == 4'd0); // R1
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (flitValid && flitReady && flitData[3:0] != LAST) |=>
      (flitValid && flitData[3:0] == $past(flitData[3:0]) + 4'd1)); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (flitValid && !flitReady) |=> (flitValid && $stable(flitData))); // R4
  AST_LAST_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (flitValid && flitReady && flitData[3:0] == LAST) |=> !flitValid); // R4
  AST_RATE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rateIn == '0 && !flitValid) |=> !flitValid); // R5
  AST_OVF_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (overflowCount == '1) |=> (overflowCount == '1)); // R6
  AST_OVF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !flitValid |=> $stable(overflowCount)); // R6
endmodule

bind spike_pkt_packetizer spike_pkt_checker #(
  .FLIT_W(FLIT_W), .NUM_TAILS(NUM_TAILS), .RATE_W(RATE_W), .OVF_W(OVF_W)
) u_chk (
  .clk(clk), .rstN(rstN), .flitData(flitData), .flitValid(flitValid),
  .flitReady(flitReady), .rateIn(rateIn), .overflowCount(overflowCount)
);

// File: tb/spike_pkt_packetizer_bench.sv
`timescale 1ns/1ps
module spike_pkt_packetizer_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         stepPulse = 1'b0;
  logic [15:0]  rateIn = '0;
  logic [6:0]   destAddr = '0;
  logic [511:0] eventPayload = '0;
  logic [63:0]  flitData;
  logic         flitValid;
  logic         flitReady = 1'b0;
  logic [7:0]   overflowCount;

  int testCount = 0;
  int failCount = 0;
  logic [63:0] rxFlit [10];

  always #5 clk = ~clk;

  spike_pkt_packetizer u_spike_pkt_packetizer (
    .clk(clk), .rstN(rstN), .stepPulse(stepPulse), .rateIn(rateIn),
    .destAddr(destAddr), .eventPayload(eventPayload), .flitData(flitData),
    .flitValid(flitValid), .flitReady(flitReady), .overflowCount(overflowCount)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; stepPulse = 1'b0; flitReady = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doStep();
    stepPulse = 1'b1;
    @(negedge clk);
    stepPulse = 1'b0;
  endtask

  function automatic logic [511:0] randPayload();
    logic [511:0] p;
    for (int i = 0; i < 16; i++) p[i*32 +: 32] = $urandom;
    return p;
  endfunction

  // Gathers ten flits; mode 1 drives random ready and checks holds.
  task automatic collect(input int mode);
    int got = 0;
    int guard = 0;
    bit prevStall = 0;
    logic [63:0] prevData = '0;
    while (got < 10 && guard < 1000) begin
      flitReady = (mode == 1) ? 1'($urandom % 2) : 1'b1;
      #1;
      if (prevStall)
        chk(flitValid && flitData == prevData, "R4 stall hold", flitData, prevData);
      prevStall = flitValid && !flitReady;
      prevData = flitData;
      if (flitValid && flitReady) begin
        rxFlit[got] = flitData;
        got++;
      end
      @(negedge clk);
      guard++;
    end
    flitReady = 1'b0;
    chk(got == 10, "R1 flit count", 64'(got), 64'd10);
    #1;
    chk(!flitValid, "R4 valid low after last tail", 64'(flitValid), 64'd0);
  endtask

  task automatic checkMessage(input logic [6:0] dest, input logic [511:0] pay);
    logic [592:0] cat;
    for (int k = 0; k < 10; k++)
      chk(rxFlit[k][3:0] == 4'(k), "R1 sequence code", 64'(rxFlit[k][3:0]), 64'(k));
    chk(rxFlit[0][63:57] == dest, "R2 destination", 64'(rxFlit[0][63:57]), 64'(dest));
    cat = '0;
    cat[592 -: 53] = rxFlit[0][56:4];
    for (int k = 1; k < 10; k++) cat[539 - 60*(k-1) -: 60] = rxFlit[k][63:4];
    for (int w = 0; w < 8; w++)
      chk(cat[81 + w*64 +: 64] == pay[w*64 +: 64], "R3 payload word", cat[81 + w*64 +: 64], pay[w*64 +: 64]);
    chk(cat[80:0] == '0, "R3 zero padding", cat[63:0], 64'd0);
  endtask

  task automatic testReset();
    doReset();
    chk(!flitValid, "R7 reset valid", 64'(flitValid), 64'd0);
    chk(overflowCount == 0, "R7 reset overflow", 64'(overflowCount), 64'd0);
  endtask

  task automatic testFullRate();
    logic [511:0] p = randPayload();
    doReset();
    rateIn = 16'hFFFF; destAddr = 7'h5A; eventPayload = p;
    chk(!flitValid, "R5 idle before step", 64'(flitValid), 64'd0);
    doStep();
    chk(flitValid, "R5 valid after step", 64'(flitValid), 64'd1);
    destAddr = 7'h11;
    collect(0);
    checkMessage(7'h5A, p);
  endtask

  task automatic testBackpressure();
    for (int m = 0; m < 3; m++) begin
      logic [511:0] p = randPayload();
      logic [6:0] d = 7'($urandom);
      rateIn = 16'hFFFF; destAddr = d; eventPayload = p;
      doStep();
      collect(1);
      checkMessage(d, p);
    end
  endtask

  task automatic testRateZero();
    bit seen = 0;
    doReset();
    rateIn = 16'h0000; flitReady = 1'b1;
    for (int i = 0; i < 60; i++) begin
      doStep();
      #1;
      if (flitValid) seen = 1;
    end
    chk(!seen, "R5 zero rate never fires", 64'(seen), 64'd0);
    chk(overflowCount == 0, "R6 no drops at zero rate", 64'(overflowCount), 64'd0);
    flitReady = 1'b0;
  endtask

  task automatic testMidRate();
    int fired = 0;
    doReset();
    rateIn = 16'h6000;
    for (int i = 0; i < 60; i++) begin
      doStep();
      #1;
      if (flitValid) begin
        fired++;
        collect(0);
      end
    end
    chk(fired > 0 && fired < 60, "R8 mid rate fires sometimes", 64'(fired), 64'd30);
    chk(overflowCount == 0, "R6 no drops when drained", 64'(overflowCount), 64'd0);
  endtask

  task automatic testOverflow();
    logic [511:0] p = randPayload();
    doReset();
    rateIn = 16'hFFFF; destAddr = 7'h2C; eventPayload = p; flitReady = 1'b0;
    doStep();
    for (int i = 0; i < 3; i++) begin
      destAddr = 7'($urandom); eventPayload = randPayload();
      doStep();
    end
    #1;
    chk(overflowCount == 8'd3, "R6 overflow counts drops", 64'(overflowCount), 64'd3);
    chk(flitValid && flitData[3:0] == 4'd0, "R6 header held during drops", flitData, 64'd0);
    for (int i = 0; i < 300; i++) doStep();
    #1;
    chk(overflowCount == 8'hFF, "R6 overflow saturates", 64'(overflowCount), 64'hFF);
    collect(0);
    checkMessage(7'h2C, p);
    chk(overflowCount == 8'hFF, "R6 overflow stays saturated", 64'(overflowCount), 64'hFF);
  endtask

  initial begin
    testReset();
    testFullRate();
    testBackpressure();
    testRateZero();
    testMidRate();
    testOverflow();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #1500000;
    testCount++;
    failCount++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule